// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR-style flash array. It watches the chip-select and write-enable strobes together with the address and data buses. It tracks the multi-write command sequences that software issues, and it turns each complete sequence into a single-cycle request to a separate program/erase engine. It also tells the read path whether a read should return array contents or engine status.

Byte program and sector erase are both guarded by a two-write unlock prefix. A sector erase opens a restartable start window. Inside that window, further confirm writes add more sectors and need no prefix. Erase suspend, erase resume and reset are single unprefixed writes. The set of writes the decoder accepts depends on what the engine is doing: it accepts nothing while a program runs, only suspend or reset while an erase runs, and only resume or reset while an erase is suspended.

A write completes when the overlap of select and write-enable ends. The address is captured when the overlap begins, and the data is taken when it ends.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `rd_status` is 0 and no request pulse (`prog_start`, `sel_valid`, `erase_start`, `suspend_req`, `resume_req`, `abort_req`) is asserted, and at most one request pulse is ever high in a cycle.
- R2: The unlock prefix is data AAh at address 5555h and then data 55h at address 2AAAh, both compared on address bits 14:0. Any mismatch sends the decoder back to idle, and a later setup code without a fresh prefix has no effect.
- R3: After the prefix, A0h at 5555h arms a program. The next write pulses `prog_start` one cycle after that write ends. `prog_addr` carries the address present when the strobe overlap began, and `prog_data` carries the data present when it ended. `rd_status` becomes 1 in the same cycle.
- R4: While a program runs, every write is ignored. No request pulse occurs and `rd_status` stays 1 until `eng_done`.
- R5: The erase sequence is prefix, 80h at 5555h, prefix, then 30h at any address. The confirm pulses `sel_valid` with `sel_sector` equal to the address shifted right by SECT_BITS, and `rd_status` becomes 1 after this sixth write.
- R6: While the erase start window is open, each further 30h write pulses `sel_valid` with its own sector, needs no prefix, and restarts the window.
- R7: `erase_start` pulses exactly WIN_CYCLES cycles after the last confirm write in the window ends. `rd_status` stays 1 from then on.
- R8: Any write other than 30h inside the window pulses `abort_req`, clears `rd_status`, and prevents `erase_start`.
- R9: While an erase runs, B0h at any address pulses `suspend_req` and clears `rd_status`. Every other write except F0h is ignored.
- R10: While an erase is suspended, 30h at any address pulses `resume_req` and sets `rd_status`. Every other write except F0h is ignored.
- R11: F0h during a running or suspended erase pulses `abort_req` and returns to read-array mode (`rd_status` 0). F0h in idle produces no pulse.
- R12: `eng_done` during a running program or erase returns the decoder to read-array mode. B0h or 30h written in idle produces no pulse.
- R13: A write exists only while `cs_n` and `we_n` are both low. A `we_n` pulse with `cs_n` high has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| we_n | input | 1 | Write enable, active low, synchronous to clk |
| addr | input | AW | Bus address |
| wdata | input | 8 | Bus write data |
| eng_done | input | 1 | Engine finished the running program or erase (one-cycle pulse) |
| prog_start | output | 1 | Start byte program (pulse) |
| prog_addr | output | AW | Byte address to program |
| prog_data | output | 8 | Byte value to program |
| sel_valid | output | 1 | Add a sector to the erase set (pulse) |
| sel_sector | output | AW-SECT_BITS | Sector number for sel_valid |
| erase_start | output | 1 | Start erasing the selected sectors (pulse) |
| suspend_req | output | 1 | Suspend the running erase (pulse) |
| resume_req | output | 1 | Resume the suspended erase (pulse) |
| abort_req | output | 1 | Abandon the erase and clear the sector set (pulse) |
| rd_status | output | 1 | 1 = reads return status, 0 = reads return array data |

## Verification
The bench builds the decoder with a 16-bit address and SECT_BITS of 12, which gives 16 sectors whose numbers show up clearly in `sel_sector`. It uses a start window of 12 cycles. That window is long enough that a second confirm can arrive between two bus writes, and short enough that the bench can count the exact expiry cycle and also confirm that an aborted window never fires. With these values, window restart, suspend and resume, and the abort paths are all reachable within a few hundred cycles.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0]  CODE_KEY_A    = 8'hAA;
  localparam logic [7:0]  CODE_KEY_B    = 8'h55;
  localparam logic [7:0]  CODE_PROG     = 8'hA0;
  localparam logic [7:0]  CODE_ERS_SET  = 8'h80;
  localparam logic [7:0]  CODE_CONFIRM  = 8'h30;
  localparam logic [7:0]  CODE_SUSPEND  = 8'hB0;
  localparam logic [7:0]  CODE_RESET    = 8'hF0;

  localparam int          KEY_AW        = 15;
  localparam logic [14:0] KEY_ADDR_A    = 15'h5555;
  localparam logic [14:0] KEY_ADDR_B    = 15'h2AAA;

  typedef enum logic [3:0] {
    ST_READ,
    ST_KEY1,
    ST_KEY2,
    ST_PGM_ARM,
    ST_PGM_RUN,
    ST_ERS_ARM,
    ST_ERS_KEY1,
    ST_ERS_KEY2,
    ST_ERS_WIN,
    ST_ERS_RUN,
    ST_ERS_SUSP
  } seq_state_e;

endpackage

// File: rtl/flash_strobe_edge.sv
module flash_strobe_edge #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  output logic          wr_evt,
  output logic [AW-1:0] wr_addr
);

  logic          strobe;
  logic          strobe_q;
  logic          fall_evt;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;

  assign strobe   = ~cs_n & ~we_n;
  assign fall_evt = strobe & ~strobe_q;
  assign wr_evt   = ~strobe & strobe_q;

  always_comb begin
    addr_d = addr_q;
    if (fall_evt) addr_d = addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      addr_q   <= '0;
    end else begin
      strobe_q <= strobe;
      if (fall_evt) addr_q <= addr_d;
    end
  end

  assign wr_addr = addr_q;

endmodule

// File: rtl/flash_erase_window.sv
module flash_erase_window #(
  parameter int WIN_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic cancel,
  output logic expire
);

  localparam int CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(WIN_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          cnt_en;

  assign expire = run_q && (cnt_q == '0);
  assign cnt_en = restart || cancel || run_q;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (restart) begin
      cnt_d = LOAD_VAL;
      run_d = 1'b1;
    end else if (cancel) begin
      run_d = 1'b0;
    end else if (run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW        = 16,
  parameter int SECT_BITS = 12,
  localparam int SW       = AW - SECT_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_evt,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          win_expire,
  input  logic          eng_done,
  output logic          win_restart,
  output logic          win_cancel,
  output logic          prog_start,
  output logic [AW-1:0] prog_addr,
  output logic [7:0]    prog_data,
  output logic          sel_valid,
  output logic [SW-1:0] sel_sector,
  output logic          erase_start,
  output logic          suspend_req,
  output logic          resume_req,
  output logic          abort_req,
  output logic          rd_status
);

  seq_state_e st_q, st_d;

  logic go_prog, go_sel, go_start, go_susp, go_res, go_abort;
  logic key_a_hit, key_b_hit, set_hit;
  logic is_confirm, is_reset, is_suspend;
  logic status_d;

  assign key_a_hit  = (wr_data == CODE_KEY_A) && (wr_addr[KEY_AW-1:0] == KEY_ADDR_A);
  assign key_b_hit  = (wr_data == CODE_KEY_B) && (wr_addr[KEY_AW-1:0] == KEY_ADDR_B);
  assign set_hit    = (wr_addr[KEY_AW-1:0] == KEY_ADDR_A);
  assign is_confirm = (wr_data == CODE_CONFIRM);
  assign is_reset   = (wr_data == CODE_RESET);
  assign is_suspend = (wr_data == CODE_SUSPEND);

  always_comb begin
    st_d        = st_q;
    go_prog     = 1'b0;
    go_sel      = 1'b0;
    go_start    = 1'b0;
    go_susp     = 1'b0;
    go_res      = 1'b0;
    go_abort    = 1'b0;
    win_restart = 1'b0;
    win_cancel  = 1'b0;
    unique case (st_q)
      ST_READ: begin
        if (wr_evt && key_a_hit) st_d = ST_KEY1;
      end
      ST_KEY1: begin
        if (wr_evt) st_d = key_b_hit ? ST_KEY2 : ST_READ;
      end
      ST_KEY2: begin
        if (wr_evt) begin
          if (set_hit && wr_data == CODE_PROG)          st_d = ST_PGM_ARM;
          else if (set_hit && wr_data == CODE_ERS_SET)  st_d = ST_ERS_ARM;
          else                                          st_d = ST_READ;
        end
      end
      ST_PGM_ARM: begin
        if (wr_evt) begin
          go_prog = 1'b1;
          st_d    = ST_PGM_RUN;
        end
      end
      ST_PGM_RUN: begin
        if (eng_done) st_d = ST_READ;
      end
      ST_ERS_ARM: begin
        if (wr_evt) st_d = key_a_hit ? ST_ERS_KEY1 : ST_READ;
      end
      ST_ERS_KEY1: begin
        if (wr_evt) st_d = key_b_hit ? ST_ERS_KEY2 : ST_READ;
      end
      ST_ERS_KEY2: begin
        if (wr_evt) begin
          if (is_confirm) begin
            go_sel      = 1'b1;
            win_restart = 1'b1;
            st_d        = ST_ERS_WIN;
          end else begin
            st_d = ST_READ;
          end
        end
      end
      ST_ERS_WIN: begin
        if (wr_evt) begin
          if (is_confirm) begin
            go_sel      = 1'b1;
            win_restart = 1'b1;
          end else begin
            go_abort   = 1'b1;
            win_cancel = 1'b1;
            st_d       = ST_READ;
          end
        end else if (win_expire) begin
          go_start = 1'b1;
          st_d     = ST_ERS_RUN;
        end
      end
      ST_ERS_RUN: begin
        if (wr_evt && is_reset) begin
          go_abort = 1'b1;
          st_d     = ST_READ;
        end else if (wr_evt && is_suspend) begin
          go_susp = 1'b1;
          st_d    = ST_ERS_SUSP;
        end else if (eng_done) begin
          st_d = ST_READ;
        end
      end
      ST_ERS_SUSP: begin
        if (wr_evt && is_reset) begin
          go_abort = 1'b1;
          st_d     = ST_READ;
        end else if (wr_evt && is_confirm) begin
          go_res = 1'b1;
          st_d   = ST_ERS_RUN;
        end
      end
      default: st_d = ST_READ;
    endcase
  end

  assign status_d = (st_d == ST_PGM_RUN) || (st_d == ST_ERS_WIN) || (st_d == ST_ERS_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_READ;
      prog_start  <= 1'b0;
      sel_valid   <= 1'b0;
      erase_start <= 1'b0;
      suspend_req <= 1'b0;
      resume_req  <= 1'b0;
      abort_req   <= 1'b0;
      rd_status   <= 1'b0;
    end else begin
      st_q        <= st_d;
      prog_start  <= go_prog;
      sel_valid   <= go_sel;
      erase_start <= go_start;
      suspend_req <= go_susp;
      resume_req  <= go_res;
      abort_req   <= go_abort;
      rd_status   <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr <= '0;
      prog_data <= '0;
    end else if (go_prog) begin
      prog_addr <= wr_addr;
      prog_data <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sector <= '0;
    end else if (go_sel) begin
      sel_sector <= wr_addr[AW-1:SECT_BITS];
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW         = 16,
  parameter int SECT_BITS  = 12,
  parameter int WIN_CYCLES = 5000,
  localparam int SW        = AW - SECT_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          eng_done,
  output logic          prog_start,
  output logic [AW-1:0] prog_addr,
  output logic [7:0]    prog_data,
  output logic          sel_valid,
  output logic [SW-1:0] sel_sector,
  output logic          erase_start,
  output logic          suspend_req,
  output logic          resume_req,
  output logic          abort_req,
  output logic          rd_status
);

  logic [1:0]    rst_pipe_q;
  logic          rst_sync_n;
  logic          wr_evt;
  logic [AW-1:0] wr_addr;
  logic          win_restart;
  logic          win_cancel;
  logic          win_expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  flash_strobe_edge #(.AW(AW)) u_edge (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cs_n    (cs_n),
    .we_n    (we_n),
    .addr    (addr),
    .wr_evt  (wr_evt),
    .wr_addr (wr_addr)
  );

  flash_erase_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (win_restart),
    .cancel  (win_cancel),
    .expire  (win_expire)
  );

  flash_seq_fsm #(.AW(AW), .SECT_BITS(SECT_BITS)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_evt      (wr_evt),
    .wr_addr     (wr_addr),
    .wr_data     (wdata),
    .win_expire  (win_expire),
    .eng_done    (eng_done),
    .win_restart (win_restart),
    .win_cancel  (win_cancel),
    .prog_start  (prog_start),
    .prog_addr   (prog_addr),
    .prog_data   (prog_data),
    .sel_valid   (sel_valid),
    .sel_sector  (sel_sector),
    .erase_start (erase_start),
    .suspend_req (suspend_req),
    .resume_req  (resume_req),
    .abort_req   (abort_req),
    .rd_status   (rd_status)
  );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic prog_start,
  input logic sel_valid,
  input logic erase_start,
  input logic suspend_req,
  input logic resume_req,
  input logic abort_req,
  input logic rd_status
);

  p_one_request_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start, sel_valid, erase_start, suspend_req, resume_req, abort_req}));

  p_prog_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> rd_status);

  p_prog_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);

  p_sel_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> rd_status);

  p_status_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_status) |-> (prog_start || sel_valid || resume_req));

  p_start_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> rd_status);

  p_abort_array_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> !rd_status);

  p_suspend_array_r9: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> !rd_status);

  p_resume_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> rd_status);

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prog_start  (prog_start),
  .sel_valid   (sel_valid),
  .erase_start (erase_start),
  .suspend_req (suspend_req),
  .resume_req  (resume_req),
  .abort_req   (abort_req),
  .rd_status   (rd_status)
);

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

  localparam int AW  = 16;
  localparam int SB  = 12;
  localparam int WIN = 12;
  localparam int SW  = AW - SB;

  logic          clk;
  logic          rst_n;
  logic          cs_n, we_n;
  logic [AW-1:0] addr;
  logic [7:0]    wdata;
  logic          eng_done;
  logic          prog_start, sel_valid, erase_start, suspend_req, resume_req, abort_req, rd_status;
  logic [AW-1:0] prog_addr;
  logic [7:0]    prog_data;
  logic [SW-1:0] sel_sector;

  int n_run = 0, n_fail = 0;
  int c_prog = 0, c_sel = 0, c_start = 0, c_susp = 0, c_res = 0, c_abort = 0;
  bit finished = 0;

  flash_cmd_decoder #(.AW(AW), .SECT_BITS(SB), .WIN_CYCLES(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .addr(addr), .wdata(wdata),
    .eng_done(eng_done), .prog_start(prog_start), .prog_addr(prog_addr),
    .prog_data(prog_data), .sel_valid(sel_valid), .sel_sector(sel_sector),
    .erase_start(erase_start), .suspend_req(suspend_req), .resume_req(resume_req),
    .abort_req(abort_req), .rd_status(rd_status)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prog_start)  c_prog++;
      if (sel_valid)   c_sel++;
      if (erase_start) c_start++;
      if (suspend_req) c_susp++;
      if (resume_req)  c_res++;
      if (abort_req)   c_abort++;
    end
  end

  function automatic int pulses();
    return c_prog + c_sel + c_start + c_susp + c_res + c_abort;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a_fall, input logic [AW-1:0] a_rise,
                           input logic [7:0] d, input bit use_cs);
    @(negedge clk);
    addr = a_fall; wdata = 8'h00; cs_n = ~use_cs; we_n = 1'b0;
    @(negedge clk);
    addr = a_rise; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    bus_write(a, a, d, 1'b1);
  endtask

  task automatic pulse_done();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
    #1;
  endtask

  task automatic erase_seq(input logic [AW-1:0] sect_addr);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(sect_addr, 8'h30);
  endtask

  task automatic wait_start(output int n);
    n = 0;
    while (!erase_start && n < 200) begin
      @(negedge clk);
      n++;
    end
    #1;
  endtask

  task automatic t_reset();
    check(rd_status == 1'b0, "R1", "rd_status after reset", rd_status, 0);
    check(pulses() == 0, "R1", "pulses after reset", pulses(), 0);
  endtask

  task automatic t_unlock_mismatch();
    int p0 = pulses();
    wr(16'h5555, 8'hAA); wr(16'h1111, 8'h55);
    wr(16'h5555, 8'hA0); wr(16'h0100, 8'h77);
    check(pulses() == p0, "R2", "bad unlock address starts nothing", pulses() - p0, 0);
    check(rd_status == 1'b0, "R2", "rd_status after bad unlock", rd_status, 0);
  endtask

  task automatic t_program();
    int p0 = c_prog;
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0);
    bus_write(16'h1234, 16'h5678, 8'h3C, 1'b1);
    check(c_prog == p0 + 1, "R3", "prog_start count", c_prog - p0, 1);
    check(prog_addr == 16'h1234, "R3", "prog_addr from strobe fall", prog_addr, 16'h1234);
    check(prog_data == 8'h3C, "R3", "prog_data", prog_data, 8'h3C);
    check(rd_status == 1'b1, "R3", "rd_status during program", rd_status, 1);
  endtask

  task automatic t_prog_ignore();
    int p0 = pulses();
    wr(16'h0000, 8'hF0); wr(16'h0000, 8'hB0); wr(16'h5555, 8'hAA); wr(16'h0000, 8'h30);
    check(pulses() == p0, "R4", "writes during program", pulses() - p0, 0);
    check(rd_status == 1'b1, "R4", "rd_status held during program", rd_status, 1);
    pulse_done();
    check(rd_status == 1'b0, "R12", "rd_status after program done", rd_status, 0);
  endtask

  task automatic t_erase_multi();
    int s0 = c_sel, e0 = c_start, n;
    erase_seq(16'h3456);
    check(c_sel == s0 + 1, "R5", "sel_valid count", c_sel - s0, 1);
    check(sel_sector == 4'h3, "R5", "first sector", sel_sector, 3);
    check(rd_status == 1'b1, "R5", "rd_status after sixth write", rd_status, 1);
    repeat (6) @(negedge clk);
    #1;
    wr(16'h9ABC, 8'h30);
    check(c_sel == s0 + 2, "R6", "second sel_valid", c_sel - s0, 2);
    check(sel_sector == 4'h9, "R6", "second sector", sel_sector, 9);
    check(c_start == e0, "R6", "window restarted, no start yet", c_start - e0, 0);
    wait_start(n);
    check(n == WIN, "R7", "cycles to erase_start", n, WIN);
    check(rd_status == 1'b1, "R7", "rd_status while erasing", rd_status, 1);
  endtask

  task automatic t_run_filter();
    int p0 = pulses(), s0 = c_susp;
    wr(16'h5555, 8'hA0); wr(16'h0000, 8'h30); wr(16'h5555, 8'hAA);
    check(pulses() == p0, "R9", "other writes ignored during erase", pulses() - p0, 0);
    wr(16'h7777, 8'hB0);
    check(c_susp == s0 + 1, "R9", "suspend_req", c_susp - s0, 1);
    check(rd_status == 1'b0, "R9", "array reads while suspended", rd_status, 0);
  endtask

  task automatic t_suspend();
    int p0 = pulses(), r0 = c_res;
    wr(16'h0000, 8'hB0); wr(16'h5555, 8'h80);
    check(pulses() == p0, "R10", "writes ignored while suspended", pulses() - p0, 0);
    wr(16'h4321, 8'h30);
    check(c_res == r0 + 1, "R10", "resume_req", c_res - r0, 1);
    check(rd_status == 1'b1, "R10", "status after resume", rd_status, 1);
  endtask

  task automatic t_reset_cmd();
    int a0 = c_abort, p0;
    wr(16'h0042, 8'hF0);
    check(c_abort == a0 + 1, "R11", "abort_req on F0 in erase", c_abort - a0, 1);
    check(rd_status == 1'b0, "R11", "read array after F0", rd_status, 0);
    p0 = pulses();
    wr(16'h0042, 8'hF0);
    check(pulses() == p0, "R11", "F0 in idle", pulses() - p0, 0);
  endtask

  task automatic t_window_abort();
    int a0 = c_abort, e0 = c_start;
    erase_seq(16'h2000);
    wr(16'h5555, 8'h80);
    check(c_abort == a0 + 1, "R8", "abort_req on foreign code in window", c_abort - a0, 1);
    check(rd_status == 1'b0, "R8", "read array after window abort", rd_status, 0);
    repeat (WIN + 4) @(negedge clk);
    #1;
    check(c_start == e0, "R8", "no erase_start after abort", c_start - e0, 0);
  endtask

  task automatic t_done_idle();
    int n, p0;
    erase_seq(16'hF000);
    check(sel_sector == 4'hF, "R5", "top sector", sel_sector, 15);
    wait_start(n);
    check(erase_start == 1'b1, "R7", "erase_start seen", erase_start, 1);
    pulse_done();
    check(rd_status == 1'b0, "R12", "read array after erase done", rd_status, 0);
    p0 = pulses();
    wr(16'h0000, 8'hB0); wr(16'h0000, 8'h30);
    check(pulses() == p0, "R12", "suspend/resume in idle", pulses() - p0, 0);
  endtask

  task automatic t_strobe();
    int p0 = c_prog;
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0);
    bus_write(16'h0ABC, 16'h0ABC, 8'h11, 1'b0);
    check(c_prog == p0, "R13", "we_n without cs_n", c_prog - p0, 0);
    wr(16'h0DEF, 8'h22);
    check(c_prog == p0 + 1, "R13", "still armed after ignored strobe", c_prog - p0, 1);
    check(prog_addr == 16'h0DEF, "R13", "prog_addr", prog_addr, 16'h0DEF);
    pulse_done();
  endtask

  initial begin
    #(10 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; we_n = 1'b1; addr = '0; wdata = '0; eng_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_unlock_mismatch();
    t_program();
    t_prog_ignore();
    t_erase_multi();
    t_run_filter();
    t_suspend();
    t_reset_cmd();
    t_window_abort();
    t_done_idle();
    t_strobe();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule